// File: doc/BRIEF.md
# Flash Command and Interrupt Controller

This block is the register-facing command front end of a NAND-style flash device. A host writes opcodes into a command register over a small synchronous 16-bit register bus. The block classifies each opcode. Array operations (load, program and erase) are handed to an external operation engine through a start pulse and an operation code. Opcodes that need no array access, such as lock, one-time-programmable access, resume, suspend and core reset, take effect at once.

When the engine reports `be_done`, the block sets the matching completion flag together with the master interrupt flag. If `be_err` is also high, it sets error flags in the controller status register. The host clears interrupt flags by writing an AND mask. Dropping the master flag also wipes the error flags. While the master flag is set, or while an engine operation is outstanding, further commands are refused.

The interrupt pin follows the master flag, with its active level chosen by bit 6 of the first configuration register. The ready pin follows bit 7 of the first configuration register whenever that register is written.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After `rst` (cold reset), the registers and pins hold these values. Configuration-1 reads 0x40C0. Configuration-2 reads 0x0000. Controller status reads 0x0000. Interrupt status reads 0x8080. `rdy` is 1, `irq` is 1 and `be_start` is 0.
- R2: `irq` equals interrupt-status bit 15 XOR the inverse of configuration-1 bit 6. It therefore follows the master flag directly when bit 6 is 1, and inverted when bit 6 is 0.
- R3: A bus write to the interrupt status register (address 4) ANDs the written data into the stored value. It never sets a bit.
- R4: If interrupt-status bit 15 is 0 after such a write, controller-status bits 10 to 13 are cleared. If bit 15 is still 1, those bits are left unchanged.
- R5: A write to the command register (address 0) is ignored while interrupt-status bit 15 is 1 or while an engine operation is outstanding. In that case the command register keeps its value and no start pulse is issued.
- R6: An accepted engine opcode produces a one-cycle `be_start` in the cycle after the write, with `be_op` giving the operation. Opcodes 0x0000 and 0x0013 give load (`be_op`=1). Opcodes 0x0080, 0x001A and 0x001B give program (2). Opcode 0x0094 gives erase (3).
- R7: On `be_done`, the interrupt status gains bit 15 plus one completion bit: bit 7 for a load, bit 6 for a program and bit 5 for an erase.
- R8: If `be_err` is high together with `be_done`, controller-status bit 10 is set along with one operation-specific bit: bit 13 for a load, bit 12 for a program and bit 11 for an erase.
- R9: Some opcodes complete at once without the engine. Opcode 0x0030 sets interrupt-status bits 15 and 5. Opcode 0x00B0 sets nothing, but it is still stored in the command register. Opcodes 0x0023, 0x0027, 0x002A, 0x002C and 0x0065 set only bit 15.
- R10: Any other opcode sets controller-status bit 10 and interrupt-status bit 15.
- R11: A hot reset is triggered by opcode 0x00F0, opcode 0x00F3 or a `warm_rst` pulse. It sets configuration-1 to 0x40C0, configuration-2 to 0, interrupt status to 0x8010 and controller status to 0, and it raises `rdy`.
- R12: Reads of configuration-1 (address 1) return the stored value with bits 4 to 0 forced to zero. A write to configuration-1 drives `rdy` from bit 7 of the written data.
- R13: Read data appears on `bus_rdata` one cycle after the address is presented. The map is: 0 command, 1 configuration-1, 2 configuration-2, 3 controller status (read-only), 4 interrupt status. All other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| warm_rst | input | 1 | Synchronous hot-reset request |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the address |
| be_start | output | 1 | One-cycle start pulse to the operation engine |
| be_op | output | 2 | Engine operation: 1 load, 2 program, 3 erase |
| be_done | input | 1 | Engine completion strobe |
| be_err | input | 1 | Engine failure, valid together with `be_done` |
| irq | output | 1 | Interrupt pin with selectable polarity |
| rdy | output | 1 | Ready pin |

## Verification
The bench tries a command while the block is still in its post-reset master-flag state, and again while an engine operation is outstanding. A design that failed to gate commands would start a second engine operation or overwrite the command register. It writes a mask that keeps bit 15 set and checks that the error flags survive, then a mask that drops bit 15 and checks that they clear. A design that cleared errors on any write, or never cleared them, fails one of these two checks. It also flips the polarity bit while the master flag is low, reads configuration-1 after writing ones into its low bits, and compares the register state after a hot reset with the state after a cold reset. This catches an inverted interrupt pin, unmasked read data, and the wrong reset value for the interrupt status.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam int IST_MASTER = 15;
  localparam int IST_RESET  = 4;
  localparam int IST_ERASE  = 5;
  localparam int IST_PROG   = 6;
  localparam int IST_LOAD   = 7;
  localparam int CST_CMD    = 10;
  localparam int CST_ERASE  = 11;
  localparam int CST_PROG   = 12;
  localparam int CST_LOAD   = 13;
  localparam int CFG_POL    = 6;
  localparam int CFG_RDY    = 7;

  typedef enum logic [1:0] {BE_NONE = 2'd0, BE_LOAD = 2'd1, BE_PROG = 2'd2, BE_ERASE = 2'd3} be_op_e;
  typedef enum logic [2:0] {K_ENGINE, K_MASTER, K_RESUME, K_SUSPEND, K_HOTRST, K_BAD} cmd_kind_e;

  typedef struct packed {
    cmd_kind_e kind;
    be_op_e    op;
  } cmd_dec_t;
endpackage

// File: rtl/fcc_cmd_decode.sv
module fcc_cmd_decode
  import fcc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] code,
  output cmd_dec_t          dec
);
  always_comb begin
    dec.kind = K_BAD;
    dec.op   = BE_NONE;
    case (code)
      DATA_W'(16'h0000), DATA_W'(16'h0013): begin
        dec.kind = K_ENGINE; dec.op = BE_LOAD;
      end
      DATA_W'(16'h0080), DATA_W'(16'h001A), DATA_W'(16'h001B): begin
        dec.kind = K_ENGINE; dec.op = BE_PROG;
      end
      DATA_W'(16'h0094): begin
        dec.kind = K_ENGINE; dec.op = BE_ERASE;
      end
      DATA_W'(16'h0030): dec.kind = K_RESUME;
      DATA_W'(16'h00B0): dec.kind = K_SUSPEND;
      DATA_W'(16'h0023), DATA_W'(16'h0027), DATA_W'(16'h002A),
      DATA_W'(16'h002C), DATA_W'(16'h0065): dec.kind = K_MASTER;
      DATA_W'(16'h00F0), DATA_W'(16'h00F3): dec.kind = K_HOTRST;
      default: dec.kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/fcc_event_regs.sv
module fcc_event_regs
  import fcc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              ist_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] ist_set,
  input  logic [DATA_W-1:0] cst_set,
  output logic [DATA_W-1:0] ist_q,
  output logic [DATA_W-1:0] cst_q
);
  localparam logic [DATA_W-1:0] IST_COLD = DATA_W'((1 << IST_MASTER) | (1 << IST_LOAD));
  localparam logic [DATA_W-1:0] IST_HOT  = DATA_W'((1 << IST_MASTER) | (1 << IST_RESET));
  localparam logic [DATA_W-1:0] ERR_MASK =
    DATA_W'((1 << CST_CMD) | (1 << CST_ERASE) | (1 << CST_PROG) | (1 << CST_LOAD));

  logic [DATA_W-1:0] ist_masked;
  logic [DATA_W-1:0] cst_kept;

  // Mask write applies first, then new events are merged in
  always_comb begin
    ist_masked = ist_wr ? (ist_q & wr_data) : ist_q;
    cst_kept   = (ist_wr && !ist_masked[IST_MASTER]) ? (cst_q & ~ERR_MASK) : cst_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ist_q <= IST_COLD;
      cst_q <= '0;
    end else if (soft_rst) begin
      ist_q <= IST_HOT;
      cst_q <= '0;
    end else begin
      ist_q <= ist_masked | ist_set;
      cst_q <= cst_kept | cst_set;
    end
  end

  assert_and_only_R3: assert property (@(posedge clk) disable iff (rst)
    (ist_wr && !soft_rst && ist_set == '0) |=> ((ist_q & ~$past(ist_q)) == '0));

  assert_err_wipe_R4: assert property (@(posedge clk) disable iff (rst)
    (ist_wr && !wr_data[IST_MASTER] && !soft_rst && ist_set == '0 && cst_set == '0)
      |=> (!ist_q[IST_MASTER] && cst_q[CST_LOAD:CST_CMD] == '0));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              warm_rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              be_start,
  output logic [1:0]        be_op,
  input  logic              be_done,
  input  logic              be_err,
  output logic              irq,
  output logic              rdy
);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CFG1 = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CFG2 = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CST  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_IST  = ADDR_W'(4);
  localparam logic [DATA_W-1:0] CFG1_INIT = DATA_W'(16'h40C0);
  localparam logic [DATA_W-1:0] CFG1_RD_MASK = ~DATA_W'(5'h1F);

  logic [DATA_W-1:0] cmd_q, cfg1_q, cfg2_q, ist_q, cst_q;
  logic [DATA_W-1:0] ist_set, cst_set;
  logic              busy_q, start_q, rdy_q;
  be_op_e            op_q;
  cmd_dec_t          dec;
  logic              cmd_wr, accept, soft_rst, fin;

  fcc_cmd_decode #(.DATA_W(DATA_W)) i_dec (.code(bus_wdata), .dec(dec));

  assign cmd_wr   = bus_wr && (bus_addr == A_CMD);
  assign accept   = cmd_wr && !ist_q[IST_MASTER] && !busy_q;
  assign soft_rst = warm_rst || (accept && dec.kind == K_HOTRST);
  assign fin      = busy_q && be_done;

  always_comb begin
    ist_set = '0;
    cst_set = '0;
    if (accept) begin
      case (dec.kind)
        K_MASTER: ist_set[IST_MASTER] = 1'b1;
        K_RESUME: begin ist_set[IST_MASTER] = 1'b1; ist_set[IST_ERASE] = 1'b1; end
        K_BAD:    begin ist_set[IST_MASTER] = 1'b1; cst_set[CST_CMD] = 1'b1; end
        default:  ;
      endcase
    end
    if (fin) begin
      ist_set[IST_MASTER] = 1'b1;
      case (op_q)
        BE_LOAD:  ist_set[IST_LOAD]  = 1'b1;
        BE_PROG:  ist_set[IST_PROG]  = 1'b1;
        BE_ERASE: ist_set[IST_ERASE] = 1'b1;
        default:  ;
      endcase
      if (be_err) begin
        cst_set[CST_CMD] = 1'b1;
        case (op_q)
          BE_LOAD:  cst_set[CST_LOAD]  = 1'b1;
          BE_PROG:  cst_set[CST_PROG]  = 1'b1;
          BE_ERASE: cst_set[CST_ERASE] = 1'b1;
          default:  ;
        endcase
      end
    end
  end

  fcc_event_regs #(.DATA_W(DATA_W)) i_evt (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .ist_wr(bus_wr && bus_addr == A_IST), .wr_data(bus_wdata),
    .ist_set(ist_set), .cst_set(cst_set),
    .ist_q(ist_q), .cst_q(cst_q)
  );

  // Engine handshake
  always_ff @(posedge clk) begin
    if (rst || warm_rst) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      op_q    <= BE_NONE;
    end else begin
      start_q <= 1'b0;
      if (accept && dec.kind == K_ENGINE) begin
        start_q <= 1'b1;
        busy_q  <= 1'b1;
        op_q    <= dec.op;
      end else if (fin) begin
        busy_q <= 1'b0;
      end
    end
  end

  // Command and configuration registers
  always_ff @(posedge clk) begin
    if (rst) cmd_q <= '0;
    else if (accept) cmd_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      cfg1_q <= CFG1_INIT;
      cfg2_q <= '0;
      rdy_q  <= 1'b1;
    end else if (bus_wr && bus_addr == A_CFG1) begin
      cfg1_q <= bus_wdata;
      rdy_q  <= bus_wdata[CFG_RDY];
    end else if (bus_wr && bus_addr == A_CFG2) begin
      cfg2_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        A_CMD:   bus_rdata <= cmd_q;
        A_CFG1:  bus_rdata <= cfg1_q & CFG1_RD_MASK;
        A_CFG2:  bus_rdata <= cfg2_q;
        A_CST:   bus_rdata <= cst_q;
        A_IST:   bus_rdata <= ist_q;
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign be_start = start_q;
  assign be_op    = op_q;
  assign rdy      = rdy_q;
  assign irq      = ist_q[IST_MASTER] ^ ~cfg1_q[CFG_POL];

  assert_cmd_gated_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !warm_rst && (ist_q[IST_MASTER] || busy_q)) |=> (!be_start && cmd_q == $past(cmd_q)));

  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    be_start |=> !be_start);

  assert_start_op_R6: assert property (@(posedge clk) disable iff (rst)
    be_start |-> (be_op != BE_NONE));

  assert_fail_flags_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && be_done && be_err && !warm_rst) |=> (cst_q[CST_CMD] && ist_q[IST_MASTER]));

  assert_rdy_follow_R12: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_CFG1 && !warm_rst) |=> (rdy == $past(bus_wdata[CFG_RDY])));
endmodule

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        warm_rst = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        be_start;
  logic [1:0]  be_op;
  logic        be_done = 1'b0;
  logic        be_err = 1'b0;
  logic        irq, rdy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t q[$];
  logic rd_req = 1'b0;
  logic rd_req_q = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_ctrl i_flash_cmd_ctrl (
    .clk(clk), .rst(rst), .warm_rst(warm_rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .be_start(be_start), .be_op(be_op), .be_done(be_done), .be_err(be_err),
    .irq(irq), .rdy(rdy)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compares read data against the scoreboard queue
  always @(posedge clk) rd_req_q <= rd_req;
  always @(negedge clk) begin
    if (rd_req_q && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(it.tag, bus_rdata, it.exp);
    end
  end

  task automatic rd(logic [2:0] a, logic [15:0] e, string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    rd_req = 1'b1;
    it.exp = e;
    it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic finish_op(logic err);
    @(negedge clk);
    be_done = 1'b1; be_err = err;
    @(negedge clk);
    be_done = 1'b0; be_err = 1'b0;
  endtask

  task automatic run_engine(logic [15:0] opc, logic [1:0] op, logic err,
                            logic [15:0] ist_exp, logic [15:0] cst_exp);
    wr(3'd0, opc);
    chk("R6 start", {15'd0, be_start}, 16'd1);
    chk("R6 op", {14'd0, be_op}, {14'd0, op});
    @(negedge clk);
    chk("R6 single pulse", {15'd0, be_start}, 16'd0);
    finish_op(err);
    rd(3'd4, ist_exp, "R7 completion flags");
    rd(3'd3, cst_exp, "R8 error flags");
    wr(3'd4, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rdy", {15'd0, rdy}, 16'd1);
    chk("R1 irq", {15'd0, irq}, 16'd1);
    chk("R1 be_start", {15'd0, be_start}, 16'd0);
    rd(3'd1, 16'h40C0, "R1 cfg1");
    rd(3'd2, 16'h0000, "R1 cfg2");
    rd(3'd3, 16'h0000, "R1 cst");
    rd(3'd4, 16'h8080, "R1 ist");

    // Command refused while master set
    wr(3'd0, 16'h0094);
    chk("R5 no start under master", {15'd0, be_start}, 16'd0);
    rd(3'd0, 16'h0000, "R5 cmd unchanged");

    // AND-mask clearing and pin polarity
    wr(3'd4, 16'hFF7F);
    rd(3'd4, 16'h8000, "R3 and mask");
    wr(3'd4, 16'hFFFF);
    rd(3'd4, 16'h8000, "R3 no set");
    chk("R2 irq high", {15'd0, irq}, 16'd1);
    wr(3'd4, 16'h0000);
    chk("R2 irq low", {15'd0, irq}, 16'd0);
    wr(3'd1, 16'h0080);
    chk("R2 inverted polarity", {15'd0, irq}, 16'd1);
    chk("R12 rdy set", {15'd0, rdy}, 16'd1);
    rd(3'd1, 16'h0080, "R12 cfg1 read");
    wr(3'd1, 16'h005F);
    chk("R12 rdy cleared", {15'd0, rdy}, 16'd0);
    chk("R2 polarity restored", {15'd0, irq}, 16'd0);
    rd(3'd1, 16'h0040, "R12 low bits masked");
    wr(3'd1, 16'h40C0);
    chk("R12 rdy back", {15'd0, rdy}, 16'd1);

    // Load, with a command attempted while busy
    wr(3'd0, 16'h0013);
    chk("R6 load start", {15'd0, be_start}, 16'd1);
    chk("R6 load op", {14'd0, be_op}, 16'd1);
    wr(3'd0, 16'h0030);
    chk("R5 no start while busy", {15'd0, be_start}, 16'd0);
    rd(3'd0, 16'h0013, "R5 cmd kept while busy");
    rd(3'd4, 16'h0000, "R5 nothing set while busy");
    finish_op(1'b0);
    chk("R2 irq on completion", {15'd0, irq}, 16'd1);
    rd(3'd4, 16'h8080, "R7 load done");
    wr(3'd4, 16'h0000);

    // Program failure and selective error wipe
    wr(3'd0, 16'h001A);
    chk("R6 prog op", {14'd0, be_op}, 16'd2);
    finish_op(1'b1);
    rd(3'd4, 16'h8040, "R7 prog done");
    rd(3'd3, 16'h1400, "R8 prog error");
    wr(3'd4, 16'h8000);
    rd(3'd3, 16'h1400, "R4 errors kept while master set");
    wr(3'd4, 16'h0000);
    rd(3'd3, 16'h0000, "R4 errors wiped");

    run_engine(16'h0094, 2'd3, 1'b1, 16'h8020, 16'h0C00);
    run_engine(16'h0000, 2'd1, 1'b1, 16'h8080, 16'h2400);
    run_engine(16'h001B, 2'd2, 1'b0, 16'h8040, 16'h0000);
    run_engine(16'h0080, 2'd2, 1'b0, 16'h8040, 16'h0000);

    // Immediate opcodes
    wr(3'd0, 16'h0030);
    chk("R9 resume no start", {15'd0, be_start}, 16'd0);
    rd(3'd4, 16'h8020, "R9 resume");
    wr(3'd4, 16'h0000);
    wr(3'd0, 16'h00B0);
    rd(3'd4, 16'h0000, "R9 suspend sets nothing");
    rd(3'd0, 16'h00B0, "R9 suspend stored");
    wr(3'd0, 16'h002A);
    rd(3'd4, 16'h8000, "R9 lock");
    wr(3'd4, 16'h0000);
    wr(3'd0, 16'h0065);
    rd(3'd4, 16'h8000, "R9 otp");
    wr(3'd4, 16'h0000);

    // Unknown opcode
    wr(3'd0, 16'h0055);
    rd(3'd4, 16'h8000, "R10 master");
    rd(3'd3, 16'h0400, "R10 cmd error");
    wr(3'd4, 16'h0000);
    rd(3'd3, 16'h0000, "R4 cmd error wiped");

    // Hot reset by opcode
    wr(3'd2, 16'h1234);
    wr(3'd1, 16'h0000);
    chk("R12 rdy low", {15'd0, rdy}, 16'd0);
    wr(3'd0, 16'h00F0);
    chk("R11 rdy raised", {15'd0, rdy}, 16'd1);
    rd(3'd1, 16'h40C0, "R11 cfg1");
    rd(3'd2, 16'h0000, "R11 cfg2");
    rd(3'd4, 16'h8010, "R11 ist");
    wr(3'd4, 16'h0000);

    // Hot reset by pin
    wr(3'd2, 16'h55AA);
    @(negedge clk); warm_rst = 1'b1;
    @(negedge clk); warm_rst = 1'b0;
    rd(3'd2, 16'h0000, "R11 pin cfg2");
    rd(3'd4, 16'h8010, "R11 pin ist");
    wr(3'd4, 16'h0000);

    // Read-only and unmapped addresses
    wr(3'd3, 16'hFFFF);
    rd(3'd3, 16'h0000, "R13 cst read-only");
    rd(3'd7, 16'h0000, "R13 unmapped");
    wr(3'd0, 16'h00F3);
    rd(3'd4, 16'h8010, "R11 second reset opcode");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule